// File: doc/BRIEF.md
# Code Flash Programming Controller

This block models the programming side of a 12K-byte on-chip code store. A host drives a simple command port (command strobe, operation code, byte address, write byte) and gets back a registered read byte with a valid pulse, a ready flag that is low while a self-timed operation runs, and the current state of three protection bits. Write, chip-erase and protection-program operations are self-timed: each holds ready low for a number of clock cycles fixed by a parameter, so a fast bench can use short durations and a real clock can use the millisecond values.

Reads stay open while an operation is in progress, which is how a host polls for completion. During a byte write, a read of the byte being written shows bit 7 inverted until the write lands. During a chip erase, every read gives 00H. A mode input picks between the two write semantics: replace mode (the byte is erased on the fly before programming) and AND mode (programming can only clear bits, so a used byte needs a chip erase first). Any programmed protection bit hides code contents behind a fixed value; only a chip erase clears the protection bits.

Top module: `cflash_prog_ctrl`

## Requirements
- R1: After reset ready stays low for exactly 3072 cycles (one storage word per cycle is set to all ones), and afterwards every code byte from 0000H to 2FFFH reads FFH.
- R2: A command with op 1 (read) or op 5 (signature read) sampled on a rising edge gives rd_valid high with the result in rd_data after that edge, for one cycle; reads are accepted whether or not ready is high.
- R3: A byte write (op 2) accepted while ready is high lowers ready after the accepting edge for exactly WRITE_CYC cycles, after which the byte reads back the new value.
- R4: While a write is in progress, a read of the address being written returns the final value with bit 7 inverted; reads of other addresses are unaffected.
- R5: With serial_mode = 1 a write replaces the stored byte; with serial_mode = 0 the stored byte becomes the bitwise AND of its old value and the write byte.
- R6: A chip erase (op 3) keeps ready low for ERASE_SER_CYC cycles when serial_mode = 1 and ERASE_PAR_CYC cycles when serial_mode = 0; every read meanwhile returns 00H; afterwards every code byte reads FFH and lock_bits is 000.
- R7: A protection program (op 4) keeps ready low for WRITE_CYC cycles, then ORs cmd_wdata[2:0] into lock_bits; no other operation clears a bit.
- R8: While any bit of lock_bits is 1, code reads return BLOCK_VAL (A5H by default); signature reads are not affected.
- R9: A signature read returns 1EH at address 030H, 53H at 031H and FFH elsewhere.
- R10: Write, erase and protection commands arriving while ready is low are dropped and change nothing.
- R11: A write to an address at or above 3000H is dropped (ready stays high), and a read there returns FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | 0 none, 1 read, 2 write, 3 erase, 4 protect, 5 signature |
| cmd_addr | input | 14 | Byte address |
| cmd_wdata | input | 8 | Write byte, or protection mask in bits 2:0 |
| serial_mode | input | 1 | 1: replace writes and serial erase time; 0: AND writes and parallel erase time |
| rd_valid | output | 1 | Read result valid for one cycle |
| rd_data | output | 8 | Read result |
| ready | output | 1 | High when no timed operation runs |
| lock_bits | output | 3 | Current protection bits |

## Verification
The bench aims at the boundaries of each timed operation: the cycle ready returns high after a write, a protection program and both erase lengths, where an off-by-one counter would show as one cycle too many or too few. It polls the byte under write, where a design that committed early or forgot the inversion would return plain data, and reads during erase, where a leaky read path would show array contents. It retries writes and erases while busy, which a design without the busy gate would accept and corrupt, and it checks AND-mode writes on a non-blank byte, which a replace-only design would get wrong. Protection reads and out-of-range addresses round it out.

// File: rtl/cflash_pkg.sv
package cflash_pkg;
   typedef enum logic [2:0] {
      OP_NOP   = 3'd0,
      OP_READ  = 3'd1,
      OP_WRITE = 3'd2,
      OP_ERASE = 3'd3,
      OP_LOCK  = 3'd4,
      OP_SIG   = 3'd5
   } cf_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WRITE,
      ST_ERASE,
      ST_LOCK
   } cf_state_e;

   localparam logic [7:0] SIG_VAL0  = 8'h1E;
   localparam logic [7:0] SIG_VAL1  = 8'h53;
   localparam int         SIG_ADDR0 = 'h030;
   localparam int         SIG_ADDR1 = 'h031;
endpackage

// File: rtl/cflash_timer.sv
module cflash_timer #(
   parameter int CW      = 32,
   parameter int RST_VAL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          run,
   output logic          zero
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= CW'(RST_VAL);
      else if (load)              cnt <= load_val;
      else if (run && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/cflash_array.sv
module cflash_array #(
   parameter int WORDS = 3072,
   parameter int LANES = 4,
   parameter int WAW   = 12
) (
   input  logic               clk,
   input  logic               we,
   input  logic [LANES-1:0]   wmask,
   input  logic [WAW-1:0]     waddr,
   input  logic [8*LANES-1:0] wdata,
   input  logic [WAW-1:0]     raddr,
   output logic [8*LANES-1:0] rdata
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] mem [WORDS];
      always_ff @(posedge clk) begin
         if (we && wmask[g]) mem[waddr] <= wdata[g*8 +: 8];
      end
      assign rdata[g*8 +: 8] = mem[raddr];
   end
endmodule

// File: rtl/cflash_rdpath.sv
module cflash_rdpath #(
   parameter logic [7:0] BLOCK_VAL = 8'hA5
) (
   input  logic       is_sig,
   input  logic       sig_hit0,
   input  logic       sig_hit1,
   input  logic       in_range,
   input  logic       erase_busy,
   input  logic       poll_hit,
   input  logic [7:0] poll_val,
   input  logic       locked,
   input  logic [7:0] arr_byte,
   output logic [7:0] rd_byte
);
   import cflash_pkg::*;

   always_comb begin
      if (erase_busy)     rd_byte = 8'h00;
      else if (is_sig)    rd_byte = sig_hit0 ? SIG_VAL0 : (sig_hit1 ? SIG_VAL1 : 8'hFF);
      else if (!in_range) rd_byte = 8'hFF;
      else if (poll_hit)  rd_byte = {~poll_val[7], poll_val[6:0]};
      else if (locked)    rd_byte = BLOCK_VAL;
      else                rd_byte = arr_byte;
   end
endmodule

// File: rtl/cflash_prog_ctrl.sv
module cflash_prog_ctrl
   import cflash_pkg::*;
#(
   parameter int         CODE_BYTES    = 12288,
   parameter int         LANES         = 4,
   parameter int         ADDR_W        = 14,
   parameter int         LOCK_BITS     = 3,
   parameter int         WRITE_CYC     = 18000,
   parameter int         ERASE_PAR_CYC = 120000,
   parameter int         ERASE_SER_CYC = 192000,
   parameter logic [7:0] BLOCK_VAL     = 8'hA5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_op,
   input  logic [ADDR_W-1:0]    cmd_addr,
   input  logic [7:0]           cmd_wdata,
   input  logic                 serial_mode,
   output logic                 rd_valid,
   output logic [7:0]           rd_data,
   output logic                 ready,
   output logic [LOCK_BITS-1:0] lock_bits
);
   localparam int WORDS = CODE_BYTES / LANES;
   localparam int WAW   = $clog2(WORDS);
   localparam int LW    = $clog2(LANES);
   localparam int CW    = 32;

   if (CODE_BYTES % LANES != 0) begin : g_bad_lanes
      $error("CODE_BYTES must be a multiple of LANES");
   end
   if (LANES < 2 || (1 << LW) != LANES) begin : g_bad_pow2
      $error("LANES must be a power of two of at least 2");
   end
   if (ERASE_PAR_CYC < WORDS || ERASE_SER_CYC < WORDS) begin : g_bad_erase
      $error("erase durations must cover one cycle per storage word");
   end
   if ((1 << ADDR_W) < CODE_BYTES) begin : g_bad_addr
      $error("ADDR_W too narrow for CODE_BYTES");
   end
   if (WRITE_CYC < 1 || LOCK_BITS < 1) begin : g_bad_misc
      $error("WRITE_CYC and LOCK_BITS must be positive");
   end

   cf_state_e            st;
   cf_op_e               op;
   logic [WAW-1:0]       sweep;
   logic [ADDR_W-1:0]    last_addr;
   logic [7:0]           last_val;
   logic [LOCK_BITS-1:0] lock_q, lock_mask;
   logic                 idle, in_range, tmr_zero, done;
   logic                 acc_w, acc_e, acc_l, rd_req;
   logic [CW-1:0]        load_val;
   logic [WAW-1:0]       cmd_word;
   logic [LW-1:0]        cmd_lane;
   logic [8*LANES-1:0]   rd_word;
   logic [7:0]           arr_byte, new_val, rd_byte;
   logic                 we;
   logic [LANES-1:0]     wmask;
   logic [WAW-1:0]       waddr;
   logic [8*LANES-1:0]   wdata;

   assign op       = cf_op_e'(cmd_op);
   assign idle     = (st == ST_IDLE);
   assign in_range = (int'(cmd_addr) < CODE_BYTES);
   assign cmd_word = WAW'(cmd_addr >> LW);
   assign cmd_lane = cmd_addr[LW-1:0];
   assign arr_byte = rd_word[{cmd_lane, 3'b000} +: 8];
   assign new_val  = serial_mode ? cmd_wdata : (arr_byte & cmd_wdata);

   assign acc_w  = cmd_valid && idle && op == OP_WRITE && in_range;
   assign acc_e  = cmd_valid && idle && op == OP_ERASE;
   assign acc_l  = cmd_valid && idle && op == OP_LOCK;
   assign rd_req = cmd_valid && (op == OP_READ || op == OP_SIG);
   assign done   = !idle && tmr_zero;

   always_comb begin
      if (acc_e) load_val = serial_mode ? CW'(ERASE_SER_CYC - 1) : CW'(ERASE_PAR_CYC - 1);
      else       load_val = CW'(WRITE_CYC - 1);
   end

   cflash_timer #(.CW(CW), .RST_VAL(WORDS - 1)) tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (acc_w | acc_e | acc_l),
      .load_val (load_val),
      .run      (!idle),
      .zero     (tmr_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_ERASE;
         sweep     <= '0;
         lock_q    <= '0;
         lock_mask <= '0;
         last_addr <= '0;
         last_val  <= '0;
      end else begin
         if (st == ST_ERASE && sweep != WAW'(WORDS - 1)) sweep <= sweep + 1'b1;
         if (idle) begin
            if (acc_w) begin
               st        <= ST_WRITE;
               last_addr <= cmd_addr;
               last_val  <= new_val;
            end else if (acc_e) begin
               st    <= ST_ERASE;
               sweep <= '0;
            end else if (acc_l) begin
               st        <= ST_LOCK;
               lock_mask <= cmd_wdata[LOCK_BITS-1:0];
            end
         end else if (done) begin
            st <= ST_IDLE;
            if (st == ST_LOCK)  lock_q <= lock_q | lock_mask;
            if (st == ST_ERASE) lock_q <= '0;
         end
      end
   end

   always_comb begin
      if (st == ST_ERASE) begin
         we    = 1'b1;
         wmask = '1;
         waddr = sweep;
         wdata = '1;
      end else begin
         we    = (st == ST_WRITE) && done;
         wmask = LANES'(1) << last_addr[LW-1:0];
         waddr = WAW'(last_addr >> LW);
         wdata = {LANES{last_val}};
      end
   end

   cflash_array #(.WORDS(WORDS), .LANES(LANES), .WAW(WAW)) arr_i (
      .clk   (clk),
      .we    (we),
      .wmask (wmask),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (cmd_word),
      .rdata (rd_word)
   );

   cflash_rdpath #(.BLOCK_VAL(BLOCK_VAL)) rdp_i (
      .is_sig     (op == OP_SIG),
      .sig_hit0   (int'(cmd_addr) == SIG_ADDR0),
      .sig_hit1   (int'(cmd_addr) == SIG_ADDR1),
      .in_range   (in_range),
      .erase_busy (st == ST_ERASE),
      .poll_hit   (st == ST_WRITE && cmd_addr == last_addr),
      .poll_val   (last_val),
      .locked     (|lock_q),
      .arr_byte   (arr_byte),
      .rd_byte    (rd_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) rd_data <= rd_byte;
      end
   end

   assign ready     = idle;
   assign lock_bits = lock_q;
endmodule

// File: rtl/cflash_prog_ctrl_chk.sv
module cflash_prog_ctrl_chk
   import cflash_pkg::*;
#(
   parameter int ADDR_W     = 14,
   parameter int LOCK_BITS  = 3,
   parameter int WRITE_CYC  = 18000,
   parameter int CODE_BYTES = 12288
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmd_valid,
   input logic [2:0]           cmd_op,
   input logic [ADDR_W-1:0]    cmd_addr,
   input logic                 ready,
   input logic                 rd_valid,
   input logic [7:0]           rd_data,
   input logic [LOCK_BITS-1:0] lock_bits,
   input cf_state_e            st
);
   int unsigned wcnt;

   always_ff @(posedge clk) begin
      if (!rst_n)              wcnt <= 0;
      else if (st == ST_WRITE) wcnt <= wcnt + 1;
      else                     wcnt <= 0;
   end

   a_r2_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == 3'(OP_READ) || cmd_op == 3'(OP_SIG))) |=> rd_valid);

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && (cmd_op == 3'(OP_READ) || cmd_op == 3'(OP_SIG))) |=> !rd_valid);

   a_r3_write_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WRITE && wcnt == WRITE_CYC - 1) |=> ready);

   // R10: a running write is not cut short by new commands
   a_r10_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WRITE && wcnt < WRITE_CYC - 1) |=> (st == ST_WRITE));

   a_r6_erase_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'(OP_READ) && st == ST_ERASE) |=> (rd_data == 8'h00));

   a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_ERASE) |=> (($past(lock_bits) & ~lock_bits) == '0));

   a_r9_sig_first: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'(OP_SIG) && int'(cmd_addr) == SIG_ADDR0 && st != ST_ERASE)
      |=> (rd_data == SIG_VAL0));

   a_r11_range_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && cmd_valid && cmd_op == 3'(OP_WRITE) && int'(cmd_addr) >= CODE_BYTES) |=> ready);
endmodule

bind cflash_prog_ctrl cflash_prog_ctrl_chk #(
   .ADDR_W     (ADDR_W),
   .LOCK_BITS  (LOCK_BITS),
   .WRITE_CYC  (WRITE_CYC),
   .CODE_BYTES (CODE_BYTES)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_addr  (cmd_addr),
   .ready     (ready),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .lock_bits (lock_bits),
   .st        (st)
);

// File: tb/cflash_prog_ctrl_tb.sv
module cflash_prog_ctrl_tb_top;
   import cflash_pkg::*;

   localparam int         CLK_PERIOD = 10;
   localparam int         CODE       = 12288;
   localparam int         NWORDS     = CODE / 4;
   localparam int         WC         = 16;
   localparam int         EP         = 3100;
   localparam int         ES         = 3200;
   localparam logic [7:0] BV         = 8'hA5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [13:0] cmd_addr = '0;
   logic [7:0]  cmd_wdata = '0;
   logic        serial_mode = 1'b1;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic        ready;
   logic [2:0]  lock_bits;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    finished = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   cflash_prog_ctrl #(
      .WRITE_CYC(WC), .ERASE_PAR_CYC(EP), .ERASE_SER_CYC(ES), .BLOCK_VAL(BV)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .serial_mode(serial_mode),
      .rd_valid(rd_valid), .rd_data(rd_data), .ready(ready), .lock_bits(lock_bits)
   );

   // behavioural reference: kind 0 idle, 1 write, 2 erase, 3 protect
   logic [7:0] mmem [CODE];
   int         mkind, mcnt;
   int         mla;
   logic [7:0] mlv;
   logic [2:0] mlock, mmask;
   logic       exp_rv;
   logic [7:0] exp_rd;

   function automatic logic [7:0] mread(input logic [2:0] op, input int a);
      if (mkind == 2) return 8'h00;
      if (op == 3'(OP_SIG)) return (a == 'h30) ? 8'h1E : ((a == 'h31) ? 8'h53 : 8'hFF);
      if (a >= CODE) return 8'hFF;
      if (mkind == 1 && a == mla) return {~mlv[7], mlv[6:0]};
      if (mlock != 3'b000) return BV;
      return mmem[a];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < CODE; i++) mmem[i] = 8'hFF;
         mkind = 2; mcnt = NWORDS; mlock = 3'b000; mmask = 3'b000;
         mla = 0; mlv = 8'h00; exp_rv = 1'b0; exp_rd = 8'h00;
      end else begin
         exp_rv = 1'b0;
         if (cmd_valid && (cmd_op == 3'(OP_READ) || cmd_op == 3'(OP_SIG))) begin
            exp_rv = 1'b1;
            exp_rd = mread(cmd_op, int'(cmd_addr));
         end
         if (mkind != 0) begin
            mcnt--;
            if (mcnt == 0) begin
               if (mkind == 1) mmem[mla] = mlv;
               if (mkind == 3) mlock = mlock | mmask;
               if (mkind == 2) begin
                  for (int i = 0; i < CODE; i++) mmem[i] = 8'hFF;
                  mlock = 3'b000;
               end
               mkind = 0;
            end
         end else if (cmd_valid) begin
            if (cmd_op == 3'(OP_WRITE) && int'(cmd_addr) < CODE) begin
               mkind = 1; mcnt = WC; mla = int'(cmd_addr);
               mlv = serial_mode ? cmd_wdata : (mmem[mla] & cmd_wdata);
            end else if (cmd_op == 3'(OP_ERASE)) begin
               mkind = 2; mcnt = serial_mode ? ES : EP;
            end else if (cmd_op == 3'(OP_LOCK)) begin
               mkind = 3; mcnt = WC; mmask = cmd_wdata[2:0];
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(ready == (mkind == 0), cur_req, "ready vs model", int'(ready), int'(mkind == 0));
         chk(rd_valid == exp_rv, cur_req, "rd_valid vs model", int'(rd_valid), int'(exp_rv));
         if (exp_rv) chk(rd_data == exp_rd, cur_req, "rd_data vs model", int'(rd_data), int'(exp_rd));
         chk(lock_bits == mlock, cur_req, "lock_bits vs model", int'(lock_bits), int'(mlock));
      end
   end

   task automatic issue(input cf_op_e op, input int a, input logic [7:0] d);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = 14'(a); cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'(OP_NOP);
   endtask

   task automatic rd_chk(input cf_op_e op, input int a, input logic [7:0] exp, input string req);
      issue(op, a, 8'h00);
      chk(rd_valid && rd_data == exp, req, $sformatf("read %0h", a), int'(rd_data), int'(exp));
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (!ready && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic summary();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int n;
      repeat (4) @(negedge clk);
      chk(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
      rst_n = 1'b1;
      busy_len(n);
      chk(n == NWORDS, "R1", "init length", n, NWORDS);
      rd_chk(OP_READ, 'h0000, 8'hFF, "R1");
      rd_chk(OP_READ, 'h2FFF, 8'hFF, "R1");

      cur_req = "R9";
      rd_chk(OP_SIG, 'h030, 8'h1E, "R9");
      rd_chk(OP_SIG, 'h031, 8'h53, "R9");
      rd_chk(OP_SIG, 'h032, 8'hFF, "R9");

      cur_req = "R4";
      serial_mode = 1'b1;
      issue(OP_WRITE, 'h100, 8'h3C);
      rd_chk(OP_READ, 'h100, 8'hBC, "R4");
      rd_chk(OP_READ, 'h101, 8'hFF, "R4");
      cur_req = "R10";
      issue(OP_WRITE, 'h200, 8'h55);
      issue(OP_ERASE, 'h000, 8'h00);
      issue(OP_LOCK, 'h000, 8'h07);
      busy_len(n);
      rd_chk(OP_READ, 'h100, 8'h3C, "R3");
      rd_chk(OP_READ, 'h200, 8'hFF, "R10");
      chk(lock_bits == 3'b000, "R10", "lock after busy protect", int'(lock_bits), 0);

      cur_req = "R3";
      issue(OP_WRITE, 'h101, 8'h7E);
      busy_len(n);
      chk(n == WC, "R3", "write busy length", n, WC);
      rd_chk(OP_READ, 'h101, 8'h7E, "R3");

      cur_req = "R5";
      serial_mode = 1'b0;
      issue(OP_WRITE, 'h100, 8'hF0);
      busy_len(n);
      rd_chk(OP_READ, 'h100, 8'h30, "R5");
      serial_mode = 1'b1;
      issue(OP_WRITE, 'h100, 8'hC3);
      busy_len(n);
      rd_chk(OP_READ, 'h100, 8'hC3, "R5");
      issue(OP_WRITE, 'h102, 8'h81);
      rd_chk(OP_READ, 'h102, 8'h01, "R4");
      busy_len(n);
      rd_chk(OP_READ, 'h102, 8'h81, "R4");

      cur_req = "R11";
      issue(OP_WRITE, 'h3000, 8'h00);
      chk(ready == 1'b1, "R11", "ready after out-of-range write", int'(ready), 1);
      rd_chk(OP_READ, 'h3000, 8'hFF, "R11");
      rd_chk(OP_READ, 'h3FFF, 8'hFF, "R11");

      cur_req = "R7";
      issue(OP_LOCK, 'h000, 8'h01);
      busy_len(n);
      chk(n == WC, "R7", "protect busy length", n, WC);
      chk(lock_bits == 3'b001, "R7", "lock bits", int'(lock_bits), 1);
      cur_req = "R8";
      rd_chk(OP_READ, 'h100, BV, "R8");
      rd_chk(OP_SIG, 'h031, 8'h53, "R8");
      cur_req = "R7";
      issue(OP_LOCK, 'h000, 8'h04);
      busy_len(n);
      chk(lock_bits == 3'b101, "R7", "lock bits accumulate", int'(lock_bits), 5);
      issue(OP_LOCK, 'h000, 8'h00);
      busy_len(n);
      chk(lock_bits == 3'b101, "R7", "lock bits not cleared", int'(lock_bits), 5);

      cur_req = "R6";
      serial_mode = 1'b0;
      issue(OP_ERASE, 'h000, 8'h00);
      busy_len(n);
      chk(n == EP, "R6", "parallel erase length", n, EP);
      chk(lock_bits == 3'b000, "R6", "lock cleared by erase", int'(lock_bits), 0);
      rd_chk(OP_READ, 'h100, 8'hFF, "R6");
      rd_chk(OP_READ, 'h102, 8'hFF, "R6");

      serial_mode = 1'b1;
      issue(OP_WRITE, 'h0, 8'h12);
      busy_len(n);
      issue(OP_ERASE, 'h000, 8'h00);
      rd_chk(OP_READ, 'h0, 8'h00, "R6");
      rd_chk(OP_SIG, 'h030, 8'h00, "R6");
      busy_len(n);
      chk(n == ES - 2, "R6", "serial erase length", n + 2, ES);
      rd_chk(OP_READ, 'h0, 8'hFF, "R6");

      cur_req = "R2";
      @(negedge clk);
      chk(rd_valid == 1'b0, "R2", "rd_valid idle", int'(rd_valid), 0);
      summary();
   end
endmodule